// File: doc/BRIEF.md
# Target Window Traffic Monitor

This block watches the transaction stream that carries host reads and writes toward device memory windows behind a set of root ports. There are two kinds of window: register/memory windows behind a port (called BAR windows here) and attached-memory windows (called CXL windows here). The block sits beside the link as a passive observer. It samples a valid/ready handshake that other logic drives. A beat counts only in a cycle where both `txn_valid` and `txn_ready` are high. The monitor never drives or stalls the link, so back-pressure from the receiver only delays the cycle in which a beat is counted.

Each accepted beat is tested against a selection rule held in a small register set. With the window filter enabled, a beat of either kind is selected when its address, masked, equals the programmed base under the same mask; the port mask is not consulted. With the window filter disabled, only BAR beats are selected, and only when the bit of the port mask for the beat's destination port is set. Selected beats add to a read or write request counter and to a read or write byte counter. A free-running cycle counter gives the time base. A write to the clear register zeroes all five counters at once.

Top module: `tmon_target_monitor`

## Requirements
- R1: After reset all five counters read 0, the window filter is disabled, base and mask are 0, and the port mask selects all ports, so a BAR beat to port 7 is counted.
- R2: A beat is counted only in a cycle where `txn_valid` and `txn_ready` are both 1; valid alone or ready alone changes no request or byte counter.
- R3: A selected beat with `txn_is_write`=0 adds 1 to `cnt_rd_req` and `txn_bytes` to `cnt_rd_bytes`. A selected beat with `txn_is_write`=1 adds 1 to `cnt_wr_req` and `txn_bytes` to `cnt_wr_bytes`. The counters are updated at the clock edge that accepts the beat.
- R4: With the window filter disabled, a BAR beat (`txn_is_cxl`=0) is selected exactly when bit `txn_port` of the port mask is 1.
- R5: With the window filter disabled, a CXL beat (`txn_is_cxl`=1) is never counted, whatever the port mask holds.
- R6: With the window filter enabled, a beat of either kind is selected exactly when (`txn_addr` & mask) == (base & mask), and the port mask is ignored. For example, base 0x10000 with mask 0xFFF00 selects 0x10000 through 0x100FF, and rejects 0x0FFFF and 0x10100.
- R7: `cnt_cycles` increases by 1 at every clock edge after reset, except at an edge where a clear takes effect.
- R8: A write with `cfg_sel`=3 zeroes all five counters at that edge. A beat accepted in the same cycle is not counted. The configuration registers keep their values.
- R9: Register writes use `cfg_sel` as follows. At 0, `cfg_wdata[7:0]` is the port mask (bit n selects port n) and `cfg_wdata[8]` enables the window filter. At 1, `cfg_wdata` is the base. At 2, it is the mask. A new setting applies to beats from the following cycle; a beat in the write cycle uses the previous setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| txn_valid | input | 1 | Observed link valid |
| txn_ready | input | 1 | Observed link ready |
| txn_is_write | input | 1 | 1 = write beat, 0 = read beat |
| txn_bytes | input | 12 | Bytes carried by the beat |
| txn_addr | input | 48 | Target address |
| txn_is_cxl | input | 1 | 1 = CXL window, 0 = BAR window |
| txn_port | input | 3 | Destination root-port index |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 control, 1 base, 2 mask, 3 clear) |
| cfg_wdata | input | 48 | Register write data |
| cnt_rd_req | output | 64 | Selected read beats |
| cnt_wr_req | output | 64 | Selected write beats |
| cnt_rd_bytes | output | 64 | Bytes of selected reads |
| cnt_wr_bytes | output | 64 | Bytes of selected writes |
| cnt_cycles | output | 64 | Clock cycles since reset or clear |

## Verification
Two events can land in the same cycle: a counted beat and a control write. The control write is either a clear or a change to the selection rule. The bench provokes both collisions. It presents a matching read beat in the same cycle as a clear, and it presents a CXL beat in the same cycle as the write that turns the window filter off. A behavioural model updates every counter on every clock. It judges the first case by the rule that the clear wins and the beat is lost. It judges the second case by the rule that the beat is judged under the setting in force before the write.

// File: rtl/tmon_pkg.sv
package tmon_pkg;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_BASE  = 2'd1,
    REG_MASK  = 2'd2,
    REG_CLEAR = 2'd3
  } reg_sel_e;

  localparam int NUM_CNT     = 5;
  localparam int IDX_RD_REQ  = 0;
  localparam int IDX_WR_REQ  = 1;
  localparam int IDX_RD_BYTE = 2;
  localparam int IDX_WR_BYTE = 3;
  localparam int IDX_CYCLE   = 4;

endpackage

// File: rtl/tmon_cfg.sv
module tmon_cfg #(
  parameter int ADDR_W    = 48,
  parameter int NUM_PORTS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_sel,
  input  logic [ADDR_W-1:0]    cfg_wdata,
  output logic [NUM_PORTS-1:0] port_mask,
  output logic                 addr_en,
  output logic [ADDR_W-1:0]    win_base,
  output logic [ADDR_W-1:0]    win_mask,
  output logic                 clear
);
  import tmon_pkg::*;

  reg_sel_e sel;
  assign sel   = reg_sel_e'(cfg_sel);
  assign clear = cfg_we && (sel == REG_CLEAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_mask <= '1;
      addr_en   <= 1'b0;
      win_base  <= '0;
      win_mask  <= '0;
    end else if (cfg_we) begin
      case (sel)
        REG_CTRL: begin
          port_mask <= cfg_wdata[NUM_PORTS-1:0];
          addr_en   <= cfg_wdata[NUM_PORTS];
        end
        REG_BASE: win_base <= cfg_wdata;
        REG_MASK: win_mask <= cfg_wdata;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/tmon_filter.sv
module tmon_filter #(
  parameter int ADDR_W    = 48,
  parameter int NUM_PORTS = 8,
  parameter int PORT_W    = 3
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 is_cxl,
  input  logic [PORT_W-1:0]    port,
  input  logic [NUM_PORTS-1:0] port_mask,
  input  logic                 addr_en,
  input  logic [ADDR_W-1:0]    win_base,
  input  logic [ADDR_W-1:0]    win_mask,
  output logic                 hit
);
  logic [NUM_PORTS-1:0] port_onehot;
  logic                 port_hit;
  logic                 win_hit;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_dec
    assign port_onehot[g] = (port == PORT_W'(g));
  end

  assign port_hit = |(port_onehot & port_mask);
  assign win_hit  = ~|((addr ^ win_base) & win_mask);
  assign hit      = addr_en ? win_hit : (!is_cxl && port_hit);
endmodule

// File: rtl/tmon_counter.sv
module tmon_counter #(
  parameter int CNT_W = 64,
  parameter int INC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc_en,
  input  logic [INC_W-1:0] inc_val,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (clear)  count <= '0;
    else if (inc_en) count <= count + CNT_W'(inc_val);
  end
endmodule

// File: rtl/tmon_target_monitor.sv
module tmon_target_monitor #(
  parameter int ADDR_W    = 48,
  parameter int BYTE_W    = 12,
  parameter int CNT_W     = 64,
  parameter int NUM_PORTS = 8,
  parameter int PORT_W    = $clog2(NUM_PORTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_valid,
  input  logic              txn_ready,
  input  logic              txn_is_write,
  input  logic [BYTE_W-1:0] txn_bytes,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic              txn_is_cxl,
  input  logic [PORT_W-1:0] txn_port,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [CNT_W-1:0]  cnt_rd_req,
  output logic [CNT_W-1:0]  cnt_wr_req,
  output logic [CNT_W-1:0]  cnt_rd_bytes,
  output logic [CNT_W-1:0]  cnt_wr_bytes,
  output logic [CNT_W-1:0]  cnt_cycles
);
  import tmon_pkg::*;

  logic [NUM_PORTS-1:0] flt_port_mask;
  logic                 flt_addr_en;
  logic [ADDR_W-1:0]    flt_base;
  logic [ADDR_W-1:0]    flt_mask;
  logic                 ctr_clear;
  logic                 txn_hit;
  logic                 beat_take;

  tmon_cfg #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS)) cfg_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .port_mask(flt_port_mask), .addr_en(flt_addr_en),
    .win_base(flt_base), .win_mask(flt_mask), .clear(ctr_clear)
  );

  tmon_filter #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) flt_i (
    .addr(txn_addr), .is_cxl(txn_is_cxl), .port(txn_port),
    .port_mask(flt_port_mask), .addr_en(flt_addr_en),
    .win_base(flt_base), .win_mask(flt_mask), .hit(txn_hit)
  );

  assign beat_take = txn_valid && txn_ready && txn_hit;

  logic [NUM_CNT-1:0] inc_en;
  logic [BYTE_W-1:0]  inc_val [NUM_CNT];
  logic [CNT_W-1:0]   cnt_q   [NUM_CNT];

  always_comb begin
    inc_en                = '0;
    inc_en[IDX_RD_REQ]    = beat_take && !txn_is_write;
    inc_en[IDX_WR_REQ]    = beat_take &&  txn_is_write;
    inc_en[IDX_RD_BYTE]   = beat_take && !txn_is_write;
    inc_en[IDX_WR_BYTE]   = beat_take &&  txn_is_write;
    inc_en[IDX_CYCLE]     = 1'b1;
    inc_val[IDX_RD_REQ]   = BYTE_W'(1);
    inc_val[IDX_WR_REQ]   = BYTE_W'(1);
    inc_val[IDX_RD_BYTE]  = txn_bytes;
    inc_val[IDX_WR_BYTE]  = txn_bytes;
    inc_val[IDX_CYCLE]    = BYTE_W'(1);
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    tmon_counter #(.CNT_W(CNT_W), .INC_W(BYTE_W)) ctr_i (
      .clk(clk), .rst_n(rst_n), .clear(ctr_clear),
      .inc_en(inc_en[g]), .inc_val(inc_val[g]), .count(cnt_q[g])
    );
  end

  assign cnt_rd_req   = cnt_q[IDX_RD_REQ];
  assign cnt_wr_req   = cnt_q[IDX_WR_REQ];
  assign cnt_rd_bytes = cnt_q[IDX_RD_BYTE];
  assign cnt_wr_bytes = cnt_q[IDX_WR_BYTE];
  assign cnt_cycles   = cnt_q[IDX_CYCLE];
endmodule

// File: rtl/tmon_target_monitor_chk.sv
module tmon_target_monitor_chk #(
  parameter int BYTE_W = 12,
  parameter int CNT_W  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txn_valid,
  input logic              txn_ready,
  input logic              txn_is_write,
  input logic [BYTE_W-1:0] txn_bytes,
  input logic              txn_is_cxl,
  input logic              cfg_we,
  input logic [1:0]        cfg_sel,
  input logic [CNT_W-1:0]  cnt_rd_req,
  input logic [CNT_W-1:0]  cnt_wr_req,
  input logic [CNT_W-1:0]  cnt_rd_bytes,
  input logic [CNT_W-1:0]  cnt_wr_bytes,
  input logic [CNT_W-1:0]  cnt_cycles,
  input logic              hit,
  input logic              addr_en
);
  logic clr;
  logic hs;
  assign clr = cfg_we && (cfg_sel == 2'd3);
  assign hs  = txn_valid && txn_ready;

  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs && !clr) |=> ($stable(cnt_rd_req) && $stable(cnt_wr_req))); // R2

  AST_RD_BYTES_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && hit && !txn_is_write && !clr) |=>
      (cnt_rd_bytes == $past(cnt_rd_bytes) + CNT_W'($past(txn_bytes)))); // R3

  AST_MISS_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !hit && !clr) |=> ($stable(cnt_rd_req) && $stable(cnt_wr_req))); // R4

  AST_CXL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && txn_is_cxl && !addr_en && !clr) |=> ($stable(cnt_rd_bytes) && $stable(cnt_wr_bytes))); // R5

  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt_cycles == $past(cnt_cycles) + CNT_W'(1))); // R7

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_rd_req == '0 && cnt_wr_req == '0 && cnt_rd_bytes == '0 &&
             cnt_wr_bytes == '0 && cnt_cycles == '0)); // R8
endmodule

bind tmon_target_monitor tmon_target_monitor_chk #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_ready(txn_ready),
  .txn_is_write(txn_is_write), .txn_bytes(txn_bytes), .txn_is_cxl(txn_is_cxl),
  .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cnt_rd_req(cnt_rd_req),
  .cnt_wr_req(cnt_wr_req), .cnt_rd_bytes(cnt_rd_bytes),
  .cnt_wr_bytes(cnt_wr_bytes), .cnt_cycles(cnt_cycles),
  .hit(txn_hit), .addr_en(flt_addr_en)
);

// File: tb/tmon_target_monitor_tb_top.sv
module tmon_target_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        txn_valid = 1'b0, txn_ready = 1'b0, txn_is_write = 1'b0, txn_is_cxl = 1'b0;
  logic [11:0] txn_bytes = '0;
  logic [47:0] txn_addr = '0;
  logic [2:0]  txn_port = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [47:0] cfg_wdata = '0;
  logic [63:0] cnt_rd_req, cnt_wr_req, cnt_rd_bytes, cnt_wr_bytes, cnt_cycles;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  // reference model state
  logic [7:0]  m_pm = 8'hFF;
  logic        m_en = 1'b0;
  logic [47:0] m_base = '0, m_mask = '0;
  logic [63:0] m_rq = '0, m_wq = '0, m_rb = '0, m_wb = '0, m_cy = '0;

  always #5 clk = ~clk;

  tmon_target_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_ready(txn_ready),
    .txn_is_write(txn_is_write), .txn_bytes(txn_bytes), .txn_addr(txn_addr),
    .txn_is_cxl(txn_is_cxl), .txn_port(txn_port), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cnt_rd_req(cnt_rd_req),
    .cnt_wr_req(cnt_wr_req), .cnt_rd_bytes(cnt_rd_bytes),
    .cnt_wr_bytes(cnt_wr_bytes), .cnt_cycles(cnt_cycles)
  );

  function automatic bit model_sel(input logic [47:0] a, input logic cxl, input logic [2:0] p);
    if (m_en) return (a & m_mask) == (m_base & m_mask);
    if (cxl) return 1'b0;
    return m_pm[p];
  endfunction

  task automatic compare();
    checks++;
    if (cnt_rd_req !== m_rq || cnt_wr_req !== m_wq || cnt_rd_bytes !== m_rb ||
        cnt_wr_bytes !== m_wb || cnt_cycles !== m_cy) begin
      errors++;
      $display("FAIL %s actual rq=%0d wq=%0d rb=%0d wb=%0d cy=%0d expected rq=%0d wq=%0d rb=%0d wb=%0d cy=%0d",
               cur_req, cnt_rd_req, cnt_wr_req, cnt_rd_bytes, cnt_wr_bytes, cnt_cycles,
               m_rq, m_wq, m_rb, m_wb, m_cy);
    end
  endtask

  task automatic tick();
    bit take;
    @(posedge clk);
    #1;
    take = txn_valid && txn_ready && model_sel(txn_addr, txn_is_cxl, txn_port);
    if (cfg_we && cfg_sel == 2'd3) begin
      m_rq = '0; m_wq = '0; m_rb = '0; m_wb = '0; m_cy = '0;
    end else begin
      m_cy = m_cy + 1;
      if (take && !txn_is_write) begin m_rq = m_rq + 1; m_rb = m_rb + 64'(txn_bytes); end
      if (take &&  txn_is_write) begin m_wq = m_wq + 1; m_wb = m_wb + 64'(txn_bytes); end
    end
    if (cfg_we) begin
      case (cfg_sel)
        2'd0: begin m_pm = cfg_wdata[7:0]; m_en = cfg_wdata[8]; end
        2'd1: m_base = cfg_wdata;
        2'd2: m_mask = cfg_wdata;
        default: ;
      endcase
    end
    compare();
  endtask

  task automatic drive(input logic v, input logic r, input logic w, input logic [11:0] b,
                       input logic [47:0] a, input logic cxl, input logic [2:0] p,
                       input logic we, input logic [1:0] sel, input logic [47:0] d);
    @(negedge clk);
    txn_valid = v; txn_ready = r; txn_is_write = w; txn_bytes = b;
    txn_addr = a; txn_is_cxl = cxl; txn_port = p;
    cfg_we = we; cfg_sel = sel; cfg_wdata = d;
    tick();
  endtask

  task automatic beat(input logic w, input logic [11:0] b, input logic [47:0] a,
                      input logic cxl, input logic [2:0] p);
    drive(1, 1, w, b, a, cxl, p, 0, 0, '0);
  endtask

  task automatic wreg(input logic [1:0] sel, input logic [47:0] d);
    drive(0, 0, 0, 0, '0, 0, 0, 1, sel, d);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    cur_req = "R1";
    compare();                          // R1 reset state all zero
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    beat(0, 12'd64, 48'h100, 0, 3'd7);  // R1 default mask: port 7 counted

    cur_req = "R2";
    drive(1, 0, 0, 12'd32, 48'h200, 0, 3'd3, 0, 0, '0);
    drive(0, 1, 1, 12'd32, 48'h200, 0, 3'd3, 0, 0, '0);
    drive(1, 1, 0, 12'd32, 48'h200, 0, 3'd3, 0, 0, '0);

    cur_req = "R3";
    beat(1, 12'd128, 48'h300, 0, 3'd1);
    beat(0, 12'd4095, 48'h300, 0, 3'd2);
    beat(1, 12'd1, 48'h300, 0, 3'd0);
    beat(1, 12'd0, 48'h300, 0, 3'd6);

    cur_req = "R4";
    wreg(2'd0, 48'h005);
    for (int p = 0; p < 8; p++) beat(p[0], 12'(16 + p), 48'h400, 0, 3'(p));

    cur_req = "R5";
    wreg(2'd0, 48'h0FF);
    for (int p = 0; p < 4; p++) beat(p[0], 12'd256, 48'h500, 1, 3'(p));

    cur_req = "R6";
    wreg(2'd1, 48'h10000);
    wreg(2'd2, 48'hFFF00);
    wreg(2'd0, 48'h100);                // enable, port mask zero
    beat(0, 12'd10, 48'h0FFFF, 0, 3'd0);
    beat(0, 12'd11, 48'h10000, 0, 3'd0);
    beat(1, 12'd12, 48'h100FF, 1, 3'd5);
    beat(1, 12'd13, 48'h10100, 1, 3'd5);
    beat(0, 12'd14, 48'hABC_0001_0080, 1, 3'd2);

    cur_req = "R9";
    drive(1, 1, 0, 12'd40, 48'h10080, 1, 3'd1, 1, 2'd0, 48'h0FF);  // old rule: counted
    beat(0, 12'd40, 48'h10080, 1, 3'd1);                          // new rule: CXL dropped
    beat(0, 12'd41, 48'h999, 0, 3'd4);                            // new rule: BAR port 4

    cur_req = "R7";
    repeat (5) drive(0, 0, 0, 0, '0, 0, 0, 0, 0, '0);

    cur_req = "R8";
    drive(1, 1, 0, 12'd50, 48'h0, 0, 3'd2, 1, 2'd3, '0);          // clear wins
    beat(1, 12'd60, 48'h0, 0, 3'd2);                               // config kept
    beat(0, 12'd70, 48'h0, 1, 3'd2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog %s actual=hung expected=done", cur_req);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule